// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block drives the timing of an external successive-approximation converter. Software programs an 8-bit control register that holds four fields: a half-way interrupt enable, a burst (continuous) mode bit, a 3-bit acquisition code and a slow-speed bit. A start trigger then begins the sequence. The block first holds an acquire strobe for an acquisition window, counted in ADC clock cycles. It then holds a convert strobe for a conversion phase, whose length depends on the speed setting. Finally it waits for the converter to report done, and after done it emits a one-cycle sample-valid pulse.

With burst mode clear, one trigger yields one conversion and an interrupt flag on its completion. With burst mode set, the block repeats the conversion a programmed number of times. It raises the flag when the whole burst has finished. If the half-way enable is set, it also raises the flag when half the burst has finished. The flag stays set until software clears it. All settings are captured at the trigger, so register writes during a burst affect only the next burst.

Top module: `adcSeqCtrl`

## Requirements
- R1: The control register resets to 0x00. Write data bit 5 is the half-way enable, bit 4 is burst mode, bits 3:1 are the acquisition code and bit 0 is slow select. Bits 7:6 are not stored and always read as 0.
- R2: For channel indices 9 to 15, the acquire strobe stays high for exactly 6 + 4 × code cycles.
- R3: For channel indices 0 to 8, the acquire strobe stays high for exactly 6 cycles, whatever the code is.
- R4: The convert strobe stays high for FAST_CONV_CYC cycles. It stays high for SLOW_CONV_CYC cycles when the register slow bit or the auxSlow input is 1.
- R5: The convert strobe starts only right after an acquire window ends, and the two strobes are never high together. The block accepts convDone only after the convert strobe has dropped. sampleValid is a single-cycle pulse in the cycle after convDone is accepted.
- R6: With burst mode clear, each trigger yields exactly one conversion, and its completion sets intFlag. This holds whatever the programmed total is.
- R7: With burst mode set, the block performs exactly burstTotal conversions back to back, and a total of 0 counts as 1. intFlag is set by the last completion and not by an earlier one, unless R8 applies. The block then stays idle.
- R8: With burst mode and the half-way enable set, intFlag is also set by the completion whose running count equals floor(total / 2). This happens at most once per burst and never when the total is 1.
- R9: intFlag stays set until an intClr pulse clears it. If a completion event and intClr occur in the same cycle, the flag ends up set.
- R10: A start trigger that arrives while a burst is running is ignored. The running burst keeps its count and timing.
- R11: The channel, code, speed, mode, half-way enable and total are captured at the trigger. Register writes during a burst do not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control register write enable |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| auxSlow | input | 1 | Mirrored slow-speed select, ORed with the register bit |
| chanIdx | input | CHAN_W | Channel selected for the next burst |
| burstTotal | input | CNT_W | Number of conversions in a burst (0 counts as 1) |
| startTrig | input | 1 | Starts a burst when the block is idle |
| intClr | input | 1 | Clears the interrupt flag |
| acqStrobe | output | 1 | High during the acquisition window |
| convStrobe | output | 1 | High during the conversion phase |
| convDone | input | 1 | Converter reports that a result is ready |
| sampleValid | output | 1 | One-cycle pulse after each accepted completion |
| intFlag | output | 1 | Sticky interrupt flag |

## Verification
The bench uses FAST_CONV_CYC = 3, SLOW_CONV_CYC = 9 and CNT_W = 4, so burst totals run from 0 to 15. Within that range it can reach the zero-total case, the total of 1 and odd totals, each of which affects where the half-way point falls. The short conversion phases keep each conversion to a few dozen cycles. Many random bursts across all sixteen channels and all eight codes therefore fit well within the run, including the longest window of 34 cycles. Directed cases cover the channel 8/9 boundary, slow selection through the auxiliary input alone, a convDone during acquisition, clear colliding with set, and register writes in the middle of a burst.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  // Acquisition window: base cycles plus a step per code unit
  localparam int unsigned ACQ_BASE         = 6;
  localparam int unsigned ACQ_STEP         = 4;
  localparam int unsigned ACQ_CODE_MAX     = 7;
  localparam int unsigned UPPER_CHAN_FIRST = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_WAIT = 2'd3
  } seqState_t;

  // Stored control fields (bits 5..0 of the register)
  typedef struct packed {
    logic       halfIe;
    logic       burst;
    logic [2:0] acqCode;
    logic       slow;
  } ctrlReg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic loadAcq;
    logic decAcq;
    logic loadConv;
    logic decConv;
    logic countDone;
  } seqStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic acqZero;
    logic convZero;
    logic lastConv;
  } seqStatus_t;

endpackage

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int unsigned FAST_CONV_CYC = 10,
  parameter int unsigned SLOW_CONV_CYC = 34,
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned CHAN_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              auxSlow,
  input  logic [CHAN_W-1:0] chanIdx,
  input  logic [CNT_W-1:0]  burstTotal,
  input  logic              intClr,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  output logic              sampleValid,
  output logic              intFlag
);

  localparam int unsigned ACQ_MAX  = ACQ_BASE + ACQ_STEP * ACQ_CODE_MAX;
  localparam int unsigned ACQ_W    = $clog2(ACQ_MAX + 1);
  localparam int unsigned CONV_MAX = (FAST_CONV_CYC > SLOW_CONV_CYC) ? FAST_CONV_CYC : SLOW_CONV_CYC;
  localparam int unsigned CONV_W   = $clog2(CONV_MAX + 1);

  // ---------------- control register ----------------
  ctrlReg_t ctrlQ;
  logic     unusedRsvdBits;

  assign unusedRsvdBits = ^regWrData[7:6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (regWrEn) begin
      ctrlQ <= ctrlReg_t'(regWrData[5:0]);
    end
  end

  assign regRdData = {2'b00, ctrlQ};

  // ---------------- configuration computed at trigger ----------------
  logic              upperChan;
  logic [ACQ_W-1:0]  acqLenNew;
  logic [CONV_W-1:0] convLenNew;
  logic [CNT_W-1:0]  totalNew;
  logic              slowNow;

  generate
    if ((2 ** CHAN_W) > UPPER_CHAN_FIRST) begin : g_upperGroup
      assign upperChan = (chanIdx >= CHAN_W'(UPPER_CHAN_FIRST));
    end else begin : g_noUpperGroup
      logic unusedChan;
      assign unusedChan = ^chanIdx;
      assign upperChan  = 1'b0;
    end
  endgenerate

  always_comb begin
    if (upperChan) begin
      acqLenNew = ACQ_W'(ACQ_BASE) + ACQ_W'(ACQ_STEP * ctrlQ.acqCode);
    end else begin
      acqLenNew = ACQ_W'(ACQ_BASE);
    end
  end

  assign slowNow = ctrlQ.slow | auxSlow;

  generate
    if (FAST_CONV_CYC == SLOW_CONV_CYC) begin : g_oneSpeed
      logic unusedSlow;
      assign unusedSlow = slowNow;
      assign convLenNew = CONV_W'(FAST_CONV_CYC);
    end else begin : g_twoSpeed
      assign convLenNew = slowNow ? CONV_W'(SLOW_CONV_CYC) : CONV_W'(FAST_CONV_CYC);
    end
  endgenerate

  assign totalNew = (burstTotal == '0) ? CNT_W'(1) : burstTotal;

  // ---------------- latched configuration ----------------
  logic              cfgBurst;
  logic              cfgHalfIe;
  logic [ACQ_W-1:0]  cfgAcqLen;
  logic [CONV_W-1:0] cfgConvLen;
  logic [CNT_W-1:0]  cfgTotal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBurst   <= 1'b0;
      cfgHalfIe  <= 1'b0;
      cfgAcqLen  <= ACQ_W'(ACQ_BASE);
      cfgConvLen <= CONV_W'(FAST_CONV_CYC);
      cfgTotal   <= CNT_W'(1);
    end else if (strb.loadCfg) begin
      cfgBurst   <= ctrlQ.burst;
      cfgHalfIe  <= ctrlQ.halfIe;
      cfgAcqLen  <= acqLenNew;
      cfgConvLen <= convLenNew;
      cfgTotal   <= totalNew;
    end
  end

  // ---------------- phase counters ----------------
  logic [ACQ_W-1:0]  acqCnt;
  logic [CONV_W-1:0] convCnt;
  logic [ACQ_W-1:0]  acqLoadVal;

  assign acqLoadVal = strb.loadCfg ? acqLenNew : cfgAcqLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acqCnt <= '0;
    end else if (strb.loadAcq) begin
      acqCnt <= acqLoadVal - ACQ_W'(1);
    end else if (strb.decAcq) begin
      acqCnt <= acqCnt - ACQ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convCnt <= '0;
    end else if (strb.loadConv) begin
      convCnt <= cfgConvLen - CONV_W'(1);
    end else if (strb.decConv) begin
      convCnt <= convCnt - CONV_W'(1);
    end
  end

  // ---------------- completion counting and flag ----------------
  logic [CNT_W-1:0] doneCnt;
  logic [CNT_W-1:0] doneNext;
  logic [CNT_W-1:0] halfMark;
  logic             fullHit;
  logic             halfHit;
  logic             flagEvt;

  assign doneNext = doneCnt + CNT_W'(1);
  assign halfMark = cfgTotal >> 1;
  assign fullHit  = (doneNext == cfgTotal);
  assign halfHit  = cfgHalfIe && (doneNext == halfMark);
  assign flagEvt  = strb.countDone && (!cfgBurst || fullHit || halfHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneCnt <= '0;
    end else if (strb.loadCfg) begin
      doneCnt <= '0;
    end else if (strb.countDone) begin
      doneCnt <= doneNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag     <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strb.countDone;
      if (flagEvt) begin
        intFlag <= 1'b1;
      end else if (intClr) begin
        intFlag <= 1'b0;
      end
    end
  end

  assign stat.acqZero  = (acqCnt == '0);
  assign stat.convZero = (convCnt == '0);
  assign stat.lastConv = !cfgBurst || (doneNext >= cfgTotal);

endmodule

// File: rtl/adcSeqControl.sv
module adcSeqControl
  import adcSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startTrig,
  input  logic       convDone,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       acqStrobe,
  output logic       convStrobe
);

  seqState_t stateQ;
  seqState_t stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startTrig) begin
          strb.loadCfg = 1'b1;
          strb.loadAcq = 1'b1;
          stateD       = ST_ACQ;
        end
      end
      ST_ACQ: begin
        if (stat.acqZero) begin
          strb.loadConv = 1'b1;
          stateD        = ST_CONV;
        end else begin
          strb.decAcq = 1'b1;
        end
      end
      ST_CONV: begin
        if (stat.convZero) begin
          stateD = ST_WAIT;
        end else begin
          strb.decConv = 1'b1;
        end
      end
      ST_WAIT: begin
        if (convDone) begin
          strb.countDone = 1'b1;
          if (stat.lastConv) begin
            stateD = ST_IDLE;
          end else begin
            strb.loadAcq = 1'b1;
            stateD       = ST_ACQ;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign acqStrobe  = (stateQ == ST_ACQ);
  assign convStrobe = (stateQ == ST_CONV);

endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int unsigned FAST_CONV_CYC = 10,
  parameter int unsigned SLOW_CONV_CYC = 34,
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned CHAN_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              auxSlow,
  input  logic [CHAN_W-1:0] chanIdx,
  input  logic [CNT_W-1:0]  burstTotal,
  input  logic              startTrig,
  input  logic              intClr,
  output logic              acqStrobe,
  output logic              convStrobe,
  input  logic              convDone,
  output logic              sampleValid,
  output logic              intFlag
);

  seqStrobe_t strb;
  seqStatus_t stat;

  adcSeqControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startTrig  (startTrig),
    .convDone   (convDone),
    .stat       (stat),
    .strb       (strb),
    .acqStrobe  (acqStrobe),
    .convStrobe (convStrobe)
  );

  adcSeqDatapath #(
    .FAST_CONV_CYC (FAST_CONV_CYC),
    .SLOW_CONV_CYC (SLOW_CONV_CYC),
    .CNT_W         (CNT_W),
    .CHAN_W        (CHAN_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .auxSlow     (auxSlow),
    .chanIdx     (chanIdx),
    .burstTotal  (burstTotal),
    .intClr      (intClr),
    .strb        (strb),
    .stat        (stat),
    .sampleValid (sampleValid),
    .intFlag     (intFlag)
  );

endmodule

// File: rtl/adcSeqChecker.sv
module adcSeqChecker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       acqStrobe,
  input logic       convStrobe,
  input logic       convDone,
  input logic       sampleValid,
  input logic       intFlag,
  input logic       intClr
);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7:6] == 2'b00);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(acqStrobe && convStrobe));

  assert_conv_after_acq_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStrobe) |-> $past(acqStrobe));

  assert_valid_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(convDone));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_flag_on_completion_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> sampleValid);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intFlag) |-> $past(intClr));

endmodule

bind adcSeqCtrl adcSeqChecker u_adcSeqChecker (
  .clk         (clk),
  .rstN        (rstN),
  .regRdData   (regRdData),
  .acqStrobe   (acqStrobe),
  .convStrobe  (convStrobe),
  .convDone    (convDone),
  .sampleValid (sampleValid),
  .intFlag     (intFlag),
  .intClr      (intClr)
);

// File: tb/tb_adcSeqCtrl.sv
`timescale 1ns/1ps
module tb_adcSeqCtrl;

  localparam int FAST = 3;
  localparam int SLOW = 9;
  localparam int CW   = 4;
  localparam int HW   = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic          auxSlow = 1'b0;
  logic [HW-1:0] chanIdx = '0;
  logic [CW-1:0] burstTotal = '0;
  logic          startTrig = 1'b0;
  logic          intClr = 1'b0;
  logic          acqStrobe;
  logic          convStrobe;
  logic          convDone = 1'b0;
  logic          sampleValid;
  logic          intFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adcSeqCtrl #(
    .FAST_CONV_CYC (FAST),
    .SLOW_CONV_CYC (SLOW),
    .CNT_W         (CW),
    .CHAN_W        (HW)
  ) dut (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .auxSlow     (auxSlow),
    .chanIdx     (chanIdx),
    .burstTotal  (burstTotal),
    .startTrig   (startTrig),
    .intClr      (intClr),
    .acqStrobe   (acqStrobe),
    .convStrobe  (convStrobe),
    .convDone    (convDone),
    .sampleValid (sampleValid),
    .intFlag     (intFlag)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expAcqLen(input int chan, input int code);
    return (chan >= 9) ? 6 + 4 * code : 6;
  endfunction

  function automatic int expConvLen(input bit slw, input bit aux);
    return (slw || aux) ? SLOW : FAST;
  endfunction

  function automatic bit expFlagEvt(input bit cont, input bit hie, input int k, input int tot);
    return !cont || (k == tot) || (hie && tot > 1 && k == tot / 2);
  endfunction

  task automatic regWrite(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // One conversion; the bench is at a negedge when this is called
  task automatic doConv(input int expAcq, input string acqTag, input int expConv, input int dly,
                        input bit glitch, input bit busyStart, input bit midWr, input bit clrAtDone);
    int n;
    bit quiet;
    n = 0;
    while (!acqStrobe && n < 200) begin @(negedge clk); n++; end
    chk(acqStrobe, "R5", "acquire window begins", acqStrobe, 1);
    n = 0; quiet = 1'b1;
    while (acqStrobe && n < 200) begin
      if (n > 0 && sampleValid) quiet = 1'b0;
      convDone  = glitch && (n == 0);
      startTrig = busyStart && (n == 1);
      @(negedge clk); n++;
    end
    convDone = 1'b0; startTrig = 1'b0;
    chk(n == expAcq, acqTag, "acquire length", n, expAcq);
    chk(convStrobe, "R5", "convert follows acquire", convStrobe, 1);
    n = 0;
    while (convStrobe && n < 200) begin
      regWrEn = midWr && (n == 0);
      regWrData = 8'($urandom);
      @(negedge clk); n++;
    end
    regWrEn = 1'b0;
    chk(n == expConv, "R4", "convert length", n, expConv);
    if (glitch) chk(quiet, "R5", "convDone ignored during acquire", int'(!quiet), 0);
    repeat (dly) @(negedge clk);
    convDone = 1'b1; intClr = clrAtDone;
    @(negedge clk);
    convDone = 1'b0; intClr = 1'b0;
    chk(sampleValid == 1'b1, "R5", "sampleValid after done", sampleValid, 1);
  endtask

  task automatic runBurst(input int chan, input int code, input bit slw, input bit aux, input bit cont,
                          input bit hie, input int total, input int dly, input bit glitch,
                          input bit busy, input bit midWr, input bit clrDone);
    int tot;
    int eAcq;
    int eConv;
    bit eFlag;
    string acqTag;
    regWrite({2'b00, hie, cont, 3'(code), slw});
    chanIdx = HW'(chan); auxSlow = aux; burstTotal = CW'(total);
    intClr = 1'b1; @(negedge clk); intClr = 1'b0;
    chk(intFlag == 1'b0, "R9", "flag cleared by intClr", intFlag, 0);
    startTrig = 1'b1; @(negedge clk); startTrig = 1'b0;
    tot   = cont ? ((total == 0) ? 1 : total) : 1;
    eAcq  = expAcqLen(chan, code);
    eConv = expConvLen(slw, aux);
    acqTag = midWr ? "R11" : ((chan >= 9) ? "R2" : "R3");
    eFlag = 1'b0;
    for (int k = 1; k <= tot; k++) begin
      doConv(eAcq, acqTag, eConv, dly, glitch && k == 1, busy && k == 1, midWr, clrDone && k == tot);
      eFlag = eFlag | expFlagEvt(cont, hie, k, tot);
      chk(intFlag == eFlag, cont ? (hie ? "R8" : "R7") : "R6", "flag after completion", intFlag, int'(eFlag));
    end
    for (int i = 0; i < 8; i++) begin
      chk(!acqStrobe && !convStrobe, busy ? "R10" : "R7", "idle after burst",
          int'(acqStrobe | convStrobe), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(regRdData == 8'h00, "R1", "register reset value", regRdData, 0);
    chk(!acqStrobe && !convStrobe && !sampleValid && !intFlag, "R1", "outputs idle at reset",
        int'({acqStrobe, convStrobe, sampleValid, intFlag}), 0);
    regWrite(8'hFF);
    chk(regRdData == 8'h3F, "R1", "reserved bits read zero", regRdData, 8'h3F);
    regWrite(8'h00);

    // Directed corners
    runBurst(8, 7, 0, 0, 0, 0, 5, 0, 0, 0, 0, 0);  // R3 edge channel, R6 single ignores total
    runBurst(9, 7, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);  // R2 longest window
    runBurst(15, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0); // R4 slow via auxSlow only
    runBurst(3, 2, 1, 0, 1, 0, 0, 2, 0, 0, 0, 0);  // R7 total 0 counts as 1
    runBurst(10, 1, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); // R8 total 1
    runBurst(12, 3, 0, 0, 1, 1, 5, 1, 0, 0, 0, 0); // R8 odd total, half at 2
    runBurst(12, 3, 0, 0, 1, 0, 6, 0, 0, 0, 0, 0); // R7 no early flag
    runBurst(5, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);  // R5 done during acquire ignored
    runBurst(11, 5, 1, 0, 1, 0, 4, 0, 0, 1, 1, 0); // R10 busy start, R11 mid-burst writes
    runBurst(2, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1);  // R9 set wins over clear
    intClr = 1'b1; @(negedge clk); intClr = 1'b0;
    chk(intFlag == 1'b0, "R9", "flag cleared after hold", intFlag, 0);

    // Constrained random bursts
    for (int i = 0; i < 40; i++) begin
      runBurst(int'($urandom_range(15, 0)), int'($urandom_range(7, 0)), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), int'($urandom_range(15, 0)), int'($urandom_range(3, 0)),
               1'($urandom_range(3, 0) == 0), 1'($urandom), 1'($urandom_range(3, 0) == 0),
               1'($urandom_range(3, 0) == 0));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule